// File: doc/BRIEF.md
# Sequential Radix-2 Multiply/Divide Unit

This block is a bit-serial arithmetic engine. It computes an unsigned product or an unsigned quotient and remainder, producing one bit per clock. Both operations share one adder/subtractor, an operand selector that offers the adder either zero or the stored multiplicand/divisor, and a double-width register pair. The only structural difference between the two operations is the shift direction. Multiplication shifts the pair right. Division shifts it left and retires one quotient bit into the vacated low bit on each cycle.

A caller places operands on the inputs and raises `start` while the unit is idle. For a multiply, the multiplicand is `a_lo` and the multiplier is `b`. For a divide, the dividend is `{a_hi, a_lo}` and the divisor is `b`.

Division uses the nonrestoring recurrence. A negative partial remainder is kept, and the next step adds the divisor instead of subtracting it. One extra cycle fixes up a negative final remainder. A single comparison, made when the operation is accepted, rejects any divide whose result cannot fit, and a zero divisor is also flagged on its own.

Top module: `seq_muldiv`

## Requirements
- R1: After a multiply is accepted, `{res_hi, res_lo}` equals `a_lo * b` as a 2W-bit value. `done` goes high W clock edges after the accepting edge.
- R2: A divide with `a_hi < b` gives `res_lo` = floor({a_hi,a_lo} / b) and `res_hi` = {a_hi,a_lo} mod b. Both flags are 0.
- R3: A divide with `a_hi >= b` performs no iterations. `div_ovf` = 1, both results are 0, `done` rises on the accepting edge itself, and `busy` stays low.
- R4: A divide with `b == 0` sets `div_zero` = 1 and also `div_ovf` = 1.
- R5: The remainder of a valid divide always lies in [0, b). When the last recurrence step leaves a negative remainder, which happens exactly when the quotient is even, one extra correction cycle is added. `done` then rises W+1 edges after acceptance instead of W.
- R6: `done` is a single-cycle pulse. `busy` is high from the edge after acceptance until the edge that raises `done`, and it is low whenever `done` is high.
- R7: `start` is ignored while `busy` is high. A second request during an operation changes neither that operation's result nor its latency.
- R8: While the unit is idle and `start` is low, `res_hi`, `res_lo`, `div_zero` and `div_ovf` hold their values.
- R9: After reset, `busy`, `done`, `res_hi`, `res_lo`, `div_zero` and `div_ovf` are all 0.
- R10: Both flags are updated when an operation is accepted. An accepted multiply, or an accepted valid divide, clears any flag left by an earlier divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; accepted only while idle |
| op_div | input | 1 | 1 = divide, 0 = multiply |
| a_hi | input | W | Upper dividend half (unused for multiply) |
| a_lo | input | W | Lower dividend half, or multiplicand |
| b | input | W | Divisor, or multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_hi | output | W | Product high half, or remainder |
| res_lo | output | W | Product low half, or quotient |
| div_zero | output | 1 | Last accepted divide had a zero divisor |
| div_ovf | output | 1 | Last accepted divide was rejected (quotient would not fit) |

## Verification
The embedded properties rely on the caller keeping every input at a known value whenever `start` may be sampled. The single-pulse property on `done` is also conditioned on `start` being low, because back-to-back rejected divides can legally raise `done` on consecutive edges.

The stimulus drives all inputs at the falling clock edge, so nothing changes near the sampling edge. It issues each new request only after the previous `done` has been seen. Divisor and dividend pairs are built explicitly: valid divides take `a_hi` below `b`, and rejected ones are chosen on purpose (equal halves, larger halves, zero divisor). A stray `start` is injected only in the middle of a running operation.

// File: rtl/seq_muldiv.sv
module seq_muldiv #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_div,
  input  logic [W-1:0] a_hi,
  input  logic [W-1:0] a_lo,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo,
  output logic         div_zero,
  output logic         div_ovf
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} st_t;

  st_t           st;
  logic          is_div, done_r, dz_r, ov_r;
  logic [W:0]    acc;
  logic [W-1:0]  ql, dreg;
  logic [CW-1:0] cnt;

  logic [W+1:0] a_in, addend, sum;
  logic         sub, accept, exc;

  assign sub    = is_div && (st == S_RUN) && !acc[W];
  assign addend = (is_div || ql[0]) ? {2'b00, dreg} : '0;
  assign a_in   = (st == S_FIX) ? {acc[W], acc}
                : is_div        ? {acc, ql[W-1]}
                :                 {2'b00, acc[W-1:0]};
  assign sum    = a_in + (sub ? ~addend : addend) + {{(W+1){1'b0}}, sub};

  assign accept = start && (st == S_IDLE);
  assign exc    = op_div && (a_hi >= b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; is_div <= 1'b0; done_r <= 1'b0; dz_r <= 1'b0; ov_r <= 1'b0;
      acc <= '0; ql <= '0; dreg <= '0; cnt <= '0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          is_div <= op_div;
          dz_r   <= op_div && (b == '0);
          ov_r   <= exc;
          dreg   <= b;
          cnt    <= CW'(W - 1);
          if (exc) begin
            acc <= '0; ql <= '0; done_r <= 1'b1;
          end else begin
            acc <= op_div ? {1'b0, a_hi} : '0;
            ql  <= a_lo;
            st  <= S_RUN;
          end
        end
        S_RUN: begin
          cnt <= cnt - 1'b1;
          if (is_div) begin
            acc <= sum[W:0];
            ql  <= {ql[W-2:0], ~sum[W+1]};
          end else begin
            acc <= {1'b0, sum[W:1]};
            ql  <= {sum[0], ql[W-1:1]};
          end
          if (cnt == '0) begin
            if (is_div && sum[W+1]) st <= S_FIX;
            else begin st <= S_IDLE; done_r <= 1'b1; end
          end
        end
        S_FIX: begin
          acc <= sum[W:0]; st <= S_IDLE; done_r <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign done     = done_r;
  assign res_hi   = acc[W-1:0];
  assign res_lo   = ql;
  assign div_zero = dz_r;
  assign div_ovf  = ov_r;

  AST_ZERO_IN_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> div_ovf); // R4
  AST_EXC_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_div && (a_hi >= b)) |=> (done && div_ovf && !busy && res_hi == '0)); // R3
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_div && !ov_r) |-> (!acc[W] && (acc[W-1:0] < dreg))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(dreg) && $stable(is_div)); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(res_hi) && $stable(res_lo) && $stable(div_zero) && $stable(div_ovf))); // R8
endmodule

// File: tb/seq_muldiv_tb.sv
module seq_muldiv_tb;
  localparam int W = 8;
  localparam int EW = 2*W + 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op_div = 1'b0;
  logic [W-1:0] a_hi = '0, a_lo = '0, b = '0;
  logic busy, done, div_zero, div_ovf;
  logic [W-1:0] res_hi, res_lo;

  int applied = 0, fails = 0;
  logic [EW-1:0] exp_q[$];
  logic [EW-1:0] last_exp;
  int popped = 0, pushed = 0;

  always #2 clk = ~clk;

  seq_muldiv #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
    .a_hi(a_hi), .a_lo(a_lo), .b(b), .busy(busy), .done(done),
    .res_hi(res_hi), .res_lo(res_lo), .div_zero(div_zero), .div_ovf(div_ovf));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    applied++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // monitor: pop expected item on each done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk("R6 unexpected done", 1, 0);
      else begin
        last_exp = exp_q.pop_front();
        chk("R1/R2 res_hi", 64'(res_hi), 64'(last_exp[EW-1 -: W]));
        chk("R1/R2 res_lo", 64'(res_lo), 64'(last_exp[W+1 -: W]));
        chk("R3/R10 div_ovf", 64'(div_ovf), 64'(last_exp[1]));
        chk("R4/R10 div_zero", 64'(div_zero), 64'(last_exp[0]));
        popped++;
      end
    end
  end

  task automatic run_op(input logic dv, input logic [W-1:0] hi, input logic [W-1:0] lo,
                        input logic [W-1:0] bb, input logic poke);
    logic [2*W-1:0] dvd, prod;
    logic [W-1:0] eh, el;
    logic ov, dz;
    int exp_lat, lat;
    dvd = {hi, lo};
    ov = dv && (hi >= bb);
    dz = dv && (bb == '0);
    if (!dv) begin prod = lo * bb; eh = prod[2*W-1:W]; el = prod[W-1:0]; exp_lat = W; end
    else if (ov) begin eh = '0; el = '0; exp_lat = 0; end
    else begin
      el = W'(dvd / bb); eh = W'(dvd % bb);
      exp_lat = el[0] ? W : W + 1;   // R5: correction cycle when quotient even
    end
    exp_q.push_back({eh, el, ov, dz});
    pushed++;
    @(negedge clk);
    op_div = dv; a_hi = hi; a_lo = lo; b = bb; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    if (!ov) chk("R6 busy after accept", 64'(busy), 1);
    else     chk("R3 busy stays low", 64'(busy), 0);
    if (poke && !ov) begin
      op_div = ~dv; a_hi = ~hi; a_lo = ~lo; b = ~bb; start = 1'b1;   // R7
      @(negedge clk); start = 1'b0; lat++;
    end
    while (!done && lat < 4*W) begin @(negedge clk); lat++; end
    chk("R1/R3/R5/R7 latency", 64'(lat), 64'(exp_lat));
    repeat (3) @(negedge clk);
    chk("R8 hold res_hi", 64'(res_hi), 64'(eh));
    chk("R8 hold res_lo", 64'(res_lo), 64'(el));
    chk("R8 hold flags", 64'({div_ovf, div_zero}), 64'({ov, dz}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 busy", 64'(busy), 0); chk("R9 done", 64'(done), 0);
    chk("R9 res", 64'({res_hi, res_lo}), 0); chk("R9 flags", 64'({div_ovf, div_zero}), 0);
    rst_n = 1'b1;
    run_op(0, 8'h00, 8'h00, 8'h37, 0);          // R1 zero
    run_op(0, 8'h00, 8'hFF, 8'hFF, 0);          // R1 max
    run_op(1, 8'hFE, 8'hFF, 8'hFF, 0);          // R2 boundary
    run_op(1, 8'h00, 8'hC8, 8'h01, 0);          // R2 divisor one
    run_op(1, 8'h00, 8'h06, 8'h03, 0);          // R5 even quotient
    run_op(1, 8'h10, 8'h00, 8'h10, 0);          // R3 equal halves
    run_op(1, 8'h80, 8'h00, 8'h05, 0);          // R3 larger
    run_op(1, 8'h00, 8'h12, 8'h00, 0);          // R4 zero divisor
    run_op(0, 8'h00, 8'h0C, 8'h0D, 0);          // R10 clears flags
    run_op(1, 8'h00, 8'h00, 8'h00, 0);          // R4
    run_op(1, 8'h03, 8'h44, 8'h09, 0);          // R10 valid divide clears flags
    run_op(0, 8'h00, 8'hA5, 8'h5A, 1);          // R7 multiply with poke
    run_op(1, 8'h21, 8'h9C, 8'h7B, 1);          // R7 divide with poke
    for (int i = 0; i < 150; i++) begin
      logic [W-1:0] rb, rh, rl;
      rb = W'($urandom_range(1, 255));
      rh = W'($urandom_range(0, int'(rb) - 1));
      rl = W'($urandom);
      if (i % 3 == 0) run_op(0, '0, rl, W'($urandom), i % 7 == 0);
      else if (i % 11 == 0) run_op(1, rb + W'($urandom_range(0, 255 - int'(rb))), rl, rb, 0);
      else run_op(1, rh, rl, rb, i % 5 == 0);
    end
    chk("R6 scoreboard drained", 64'(popped), 64'(pushed));
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule